// File: doc/BRIEF.md
# Execution Mode and Stack Pointer Controller

This block keeps the architectural state that decides how a small processor core runs at any instant: whether it is in thread mode (ordinary task code) or handler mode (exception service code), whether the running code holds privilege, and which of two banked stack pointers, main or process, is the live one. A two-bit control register sets privilege and stack choice for thread mode. Handler mode overrides both: it is always privileged and always on the main stack.

Exception entry and return logic drives the mode change requests. The instruction path writes the control register, and each write carries the privilege of the code that issued it. Stack pointer writes go to an explicitly named bank. The block presents the live privilege, the live stack pointer value, and a guard on instruction fetch. The guard flags any thread-mode fetch from the top sixteenth of the address space, which is kept non-executable so that a stray exception-return token cannot be run as code.

Top module: `pmsc_top`

## Requirements
- R1: After reset the block is in thread mode, the control register reads 0, priv_o is 1, the main stack is live (sp_sel_o = 0), both stack pointers read 0 and fetch_fault_o is 0.
- R2: exc_enter_i puts the block in handler mode on the next cycle. exc_return_i with ret_to_thread_i = 1 puts it in thread mode on the next cycle. exc_return_i with ret_to_thread_i = 0 leaves it in handler mode. When entry and return are requested in the same cycle, entry wins.
- R3: In thread mode, privilege is the inverse of control bit 0: bit 0 = 1 means unprivileged (priv_o = 0), and bit 0 = 0 means privileged.
- R4: In handler mode, priv_o = 1 and sp_sel_o = 0 whatever the control register holds.
- R5: A control write with ctrl_wr_priv_i = 1 loads ctrl_wr_data_i into the control register on the next cycle. A write with ctrl_wr_priv_i = 0 leaves the register unchanged.
- R6: In thread mode, control bit 1 chooses the live stack (1 = process, sp_sel_o = 1; 0 = main). sp_o always shows the value of the live bank.
- R7: A stack pointer write loads sp_wr_data_i into the main bank (sp_wr_sel_i = 0) or the process bank (sp_wr_sel_i = 1), with bits [1:0] stored as zero.
- R8: A write to control bit 1 made in handler mode shows up in ctrl_o at once but does not change the live stack until the return to thread mode.
- R9: A thread-mode fetch whose address has bits [31:28] all ones raises fetch_fault_o for exactly the next cycle, with fault_addr_o holding that address. Fetches in handler mode never fault, and neither do fetches below that range.
- R10: The fetch check uses the mode in force during the fetch cycle, even if a mode change is requested in that same cycle. A control write and a mode change in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| exc_enter_i | input | 1 | Exception entry request |
| exc_return_i | input | 1 | Exception return request |
| ret_to_thread_i | input | 1 | Return goes to thread mode (1) or stays in handler (0) |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wr_priv_i | input | 1 | Privilege of the writing code |
| ctrl_wr_data_i | input | 2 | Control write data: bit 0 unprivileged, bit 1 process stack |
| sp_wr_i | input | 1 | Stack pointer write strobe |
| sp_wr_sel_i | input | 1 | Bank to write: 0 main, 1 process |
| sp_wr_data_i | input | 32 | Stack pointer write data |
| fetch_valid_i | input | 1 | Instruction fetch in this cycle |
| fetch_addr_i | input | 32 | Fetch address |
| handler_o | output | 1 | 1 in handler mode |
| ctrl_o | output | 2 | Control register contents |
| priv_o | output | 1 | Effective privilege |
| sp_sel_o | output | 1 | Live stack: 0 main, 1 process |
| sp_o | output | 32 | Value of the live stack pointer |
| fetch_fault_o | output | 1 | One-cycle fetch fault pulse |
| fault_addr_o | output | 32 | Address of the faulting fetch |

## Verification
Two pairs of functions can act in the same cycle. A mode change can coincide with a protected fetch: the bench issues a fetch to the reserved range together with an entry request in thread mode, and together with a return to thread in handler mode. The fault must follow the mode in force before the edge. A mode change can also coincide with a control write, and the bench then expects both the new mode and the new control value, with the live stack worked out from both. A cycle model in the bench predicts every output after every cycle, and sweeps cover all control values in both modes and every value of the top address nibble.

// File: rtl/pmsc_pkg.sv
package pmsc_pkg;

   typedef enum logic {
      MODE_THREAD  = 1'b0,
      MODE_HANDLER = 1'b1
   } exec_mode_e;

   localparam int CTRL_W         = 2;
   localparam int CTRL_UNPRIV_IX = 0;
   localparam int CTRL_PSTACK_IX = 1;

   // live stack select: process only when in thread mode with the select bit set
   function automatic logic live_stack_sel(exec_mode_e mode, logic pstack_bit);
      return (mode == MODE_THREAD) && pstack_bit;
   endfunction

   function automatic logic live_priv(exec_mode_e mode, logic unpriv_bit);
      return (mode == MODE_HANDLER) || !unpriv_bit;
   endfunction

endpackage

// File: rtl/pmsc_mode_fsm.sv
module pmsc_mode_fsm
   import pmsc_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       enter_i,
   input  logic       return_i,
   input  logic       to_thread_i,
   output exec_mode_e mode_o
);

   exec_mode_e mode_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         mode_q <= MODE_THREAD;
      end else if (enter_i) begin
         mode_q <= MODE_HANDLER;
      end else if (return_i && to_thread_i) begin
         mode_q <= MODE_THREAD;
      end
   end

   assign mode_o = mode_q;

   a_r2_entry_to_handler: assert property (@(posedge clk_i) disable iff (!rst_ni)
      enter_i |=> (mode_o == MODE_HANDLER));

   a_r2_return_to_thread: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (return_i && to_thread_i && !enter_i) |=> (mode_o == MODE_THREAD));

   a_r2_stay_handler: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == MODE_HANDLER && !(return_i && to_thread_i)) |=> (mode_o == MODE_HANDLER));

endmodule

// File: rtl/pmsc_ctrl_reg.sv
module pmsc_ctrl_reg #(
   parameter int W = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         wr_i,
   input  logic         wr_priv_i,
   input  logic [W-1:0] wr_data_i,
   output logic [W-1:0] ctrl_o
);

   logic [W-1:0] ctrl_q;
   logic         wr_ok;

   assign wr_ok = wr_i && wr_priv_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ctrl_q <= '0;
      end else if (wr_ok) begin
         ctrl_q <= wr_data_i;
      end
   end

   assign ctrl_o = ctrl_q;

   a_r5_unpriv_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_i || !wr_priv_i) |=> $stable(ctrl_o));

   a_r5_priv_write_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && wr_priv_i) |=> (ctrl_o == $past(wr_data_i)));

endmodule

// File: rtl/pmsc_sp_bank.sv
module pmsc_sp_bank #(
   parameter int ADDR_W    = 32,
   parameter int ZERO_BITS = 2,
   parameter int NBANKS    = 2
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      wr_i,
   input  logic [$clog2(NBANKS)-1:0] wr_sel_i,
   input  logic [ADDR_W-1:0]         wr_data_i,
   input  logic [$clog2(NBANKS)-1:0] rd_sel_i,
   output logic [ADDR_W-1:0]         rd_data_o
);

   localparam int                SEL_W     = $clog2(NBANKS);
   localparam logic [ADDR_W-1:0] KEEP_MASK = {ADDR_W{1'b1}} << ZERO_BITS;

   logic [ADDR_W-1:0] bank_val [NBANKS];

   generate
      if (ZERO_BITS < 0 || ZERO_BITS >= ADDR_W) begin : g_bad_zero
         $error("pmsc_sp_bank: ZERO_BITS out of range");
      end
      for (genvar b = 0; b < NBANKS; b++) begin : g_bank
         logic [ADDR_W-1:0] sp_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               sp_q <= '0;
            end else if (wr_i && (wr_sel_i == SEL_W'(b))) begin
               sp_q <= wr_data_i & KEEP_MASK;
            end
         end
         assign bank_val[b] = sp_q;
      end
   endgenerate

   assign rd_data_o = bank_val[rd_sel_i];

   a_r7_bank_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && (wr_sel_i == rd_sel_i)) |=>
         ((rd_sel_i != $past(rd_sel_i)) || ((rd_data_o >> ZERO_BITS) == ($past(wr_data_i) >> ZERO_BITS))));

endmodule

// File: rtl/pmsc_fetch_guard.sv
module pmsc_fetch_guard
   import pmsc_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int PROT_BITS = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              valid_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  exec_mode_e        mode_i,
   output logic              fault_o,
   output logic [ADDR_W-1:0] fault_addr_o
);

   logic in_range;
   logic hit;

   generate
      if (PROT_BITS < 1 || PROT_BITS > ADDR_W) begin : g_bad_prot
         $error("pmsc_fetch_guard: PROT_BITS out of range");
      end
   endgenerate

   assign in_range = &addr_i[ADDR_W-1 -: PROT_BITS];
   assign hit      = valid_i && (mode_i == MODE_THREAD) && in_range;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         fault_o      <= 1'b0;
         fault_addr_o <= '0;
      end else begin
         fault_o <= hit;
         if (hit) begin
            fault_addr_o <= addr_i;
         end
      end
   end

   a_r9_handler_never_faults: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!valid_i || mode_i == MODE_HANDLER) |=> !fault_o);

   a_r9_fault_carries_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_o |-> (&fault_addr_o[ADDR_W-1 -: PROT_BITS]));

endmodule

// File: rtl/pmsc_top.sv
module pmsc_top
   import pmsc_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int SP_ZERO   = 2,
   parameter int PROT_BITS = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              exc_enter_i,
   input  logic              exc_return_i,
   input  logic              ret_to_thread_i,
   input  logic              ctrl_wr_i,
   input  logic              ctrl_wr_priv_i,
   input  logic [1:0]        ctrl_wr_data_i,
   input  logic              sp_wr_i,
   input  logic              sp_wr_sel_i,
   input  logic [ADDR_W-1:0] sp_wr_data_i,
   input  logic              fetch_valid_i,
   input  logic [ADDR_W-1:0] fetch_addr_i,
   output logic              handler_o,
   output logic [1:0]        ctrl_o,
   output logic              priv_o,
   output logic              sp_sel_o,
   output logic [ADDR_W-1:0] sp_o,
   output logic              fetch_fault_o,
   output logic [ADDR_W-1:0] fault_addr_o
);

   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("pmsc_top: ADDR_W too small");
      end
   endgenerate

   exec_mode_e        mode;
   logic [CTRL_W-1:0] ctrl;
   logic              stack_sel;

   pmsc_mode_fsm u_mode (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .enter_i     (exc_enter_i),
      .return_i    (exc_return_i),
      .to_thread_i (ret_to_thread_i),
      .mode_o      (mode)
   );

   pmsc_ctrl_reg #(.W(CTRL_W)) u_ctrl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (ctrl_wr_i),
      .wr_priv_i (ctrl_wr_priv_i),
      .wr_data_i (ctrl_wr_data_i),
      .ctrl_o    (ctrl)
   );

   assign stack_sel = live_stack_sel(mode, ctrl[CTRL_PSTACK_IX]);

   pmsc_sp_bank #(.ADDR_W(ADDR_W), .ZERO_BITS(SP_ZERO), .NBANKS(2)) u_sp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (sp_wr_i),
      .wr_sel_i  (sp_wr_sel_i),
      .wr_data_i (sp_wr_data_i),
      .rd_sel_i  (stack_sel),
      .rd_data_o (sp_o)
   );

   pmsc_fetch_guard #(.ADDR_W(ADDR_W), .PROT_BITS(PROT_BITS)) u_guard (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .valid_i      (fetch_valid_i),
      .addr_i       (fetch_addr_i),
      .mode_i       (mode),
      .fault_o      (fetch_fault_o),
      .fault_addr_o (fault_addr_o)
   );

   assign handler_o = (mode == MODE_HANDLER);
   assign ctrl_o    = ctrl;
   assign sp_sel_o  = stack_sel;
   assign priv_o    = live_priv(mode, ctrl[CTRL_UNPRIV_IX]);

   a_r4_handler_overrides: assert property (@(posedge clk_i) disable iff (!rst_ni)
      handler_o |-> (priv_o && !sp_sel_o));

   a_r8_stack_held_in_handler: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (handler_o && !exc_return_i) |=> !sp_sel_o);

   a_r3_thread_unpriv: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!handler_o && ctrl_o[CTRL_UNPRIV_IX]) |-> !priv_o);

endmodule

// File: tb/pmsc_top_tb_top.sv
module pmsc_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enter = 1'b0, ret = 1'b0, rthr = 1'b0;
   logic        cw = 1'b0, cpriv = 1'b0;
   logic [1:0]  cdata = 2'b00;
   logic        sw = 1'b0, ssel = 1'b0;
   logic [31:0] sdata = '0;
   logic        fv = 1'b0;
   logic [31:0] faddr = '0;
   logic        handler_o, priv_o, sp_sel_o, fetch_fault_o;
   logic [1:0]  ctrl_o;
   logic [31:0] sp_o, fault_addr_o;

   int checks = 0;
   int failures = 0;

   // bench model
   logic        m_hdl = 1'b0;
   logic [1:0]  m_ctrl = 2'b00;
   logic [31:0] m_sp [2] = '{32'h0, 32'h0};
   logic        m_fault = 1'b0;
   logic [31:0] m_faddr = '0;

   always #2 clk = ~clk;

   pmsc_top dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .exc_enter_i(enter), .exc_return_i(ret), .ret_to_thread_i(rthr),
      .ctrl_wr_i(cw), .ctrl_wr_priv_i(cpriv), .ctrl_wr_data_i(cdata),
      .sp_wr_i(sw), .sp_wr_sel_i(ssel), .sp_wr_data_i(sdata),
      .fetch_valid_i(fv), .fetch_addr_i(faddr),
      .handler_o(handler_o), .ctrl_o(ctrl_o), .priv_o(priv_o), .sp_sel_o(sp_sel_o),
      .sp_o(sp_o), .fetch_fault_o(fetch_fault_o), .fault_addr_o(fault_addr_o)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      logic sel;
      sel = !m_hdl && m_ctrl[1];
      chk(req, "handler", 32'(handler_o), 32'(m_hdl));
      chk(req, "ctrl", 32'(ctrl_o), 32'(m_ctrl));
      chk(req, "priv", 32'(priv_o), 32'(m_hdl || !m_ctrl[0]));
      chk(req, "sp_sel", 32'(sp_sel_o), 32'(sel));
      chk(req, "sp", sp_o, m_sp[sel]);
      chk(req, "fault", 32'(fetch_fault_o), 32'(m_fault));
      if (m_fault) chk(req, "fault_addr", fault_addr_o, m_faddr);
   endtask

   // one clock cycle of stimulus; inputs applied at negedge, model advanced, checked at next negedge
   task automatic cyc(input logic e, input logic r, input logic rt,
                      input logic w, input logic wp, input logic [1:0] wd,
                      input logic s, input logic ss, input logic [31:0] sd,
                      input logic f, input logic [31:0] fa, input string req);
      enter = e; ret = r; rthr = rt; cw = w; cpriv = wp; cdata = wd;
      sw = s; ssel = ss; sdata = sd; fv = f; faddr = fa;
      m_fault = f && !m_hdl && (fa[31:28] == 4'hF);
      if (m_fault) m_faddr = fa;
      if (w && wp) m_ctrl = wd;
      if (s) m_sp[ss] = {sd[31:2], 2'b00};
      if (e) m_hdl = 1'b1;
      else if (r && rt) m_hdl = 1'b0;
      @(posedge clk);
      @(negedge clk);
      enter = 0; ret = 0; rthr = 0; cw = 0; cpriv = 0; cdata = 0;
      sw = 0; ssel = 0; sdata = 0; fv = 0; faddr = 0;
      check_all(req);
   endtask

   task automatic idle(input string req);
      cyc(0,0,0, 0,0,2'b00, 0,0,32'h0, 0,32'h0, req);
   endtask

   task automatic wctrl(input logic wp, input logic [1:0] d, input string req);
      cyc(0,0,0, 1,wp,d, 0,0,32'h0, 0,32'h0, req);
   endtask

   task automatic wsp(input logic sel, input logic [31:0] d, input string req);
      cyc(0,0,0, 0,0,2'b00, 1,sel,d, 0,32'h0, req);
   endtask

   initial begin : watchdog
      #400000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check_all("R1");                     // reset state
      idle("R1");

      // R7: bank writes drop the two low bits
      wsp(1'b0, 32'h2000_1003, "R7");
      wsp(1'b1, 32'h1000_0FFF, "R7");
      wsp(1'b1, 32'h1000_0FF6, "R7");

      // R3 / R5 / R6: all control values in thread mode
      for (int v = 0; v < 4; v++) begin
         wctrl(1'b1, 2'(v), "R6");
         idle("R3");
      end
      wctrl(1'b1, 2'b00, "R5");
      for (int v = 1; v < 4; v++) begin
         wctrl(1'b0, 2'(v), "R5");        // unprivileged: must not stick
      end

      // R2 / R4 / R8: handler mode ignores control bits for stack and privilege
      wctrl(1'b1, 2'b11, "R3");
      cyc(1,0,0, 0,0,2'b00, 0,0,32'h0, 0,32'h0, "R2");
      for (int v = 0; v < 4; v++) begin
         wctrl(1'b1, 2'(v), "R8");
         idle("R4");
      end
      wctrl(1'b1, 2'b10, "R8");
      wsp(1'b1, 32'h3000_0044, "R8");      // process bank write while main is live
      cyc(0,1,0, 0,0,2'b00, 0,0,32'h0, 0,32'h0, "R2");   // return staying in handler
      cyc(0,1,1, 0,0,2'b00, 0,0,32'h0, 0,32'h0, "R8");   // back to thread, process stack now live

      // R2: entry beats return in the same cycle
      cyc(1,1,1, 0,0,2'b00, 0,0,32'h0, 0,32'h0, "R2");
      // R10: return to thread and control write together
      cyc(0,1,1, 1,1,2'b01, 0,0,32'h0, 0,32'h0, "R10");
      cyc(1,0,0, 1,1,2'b10, 0,0,32'h0, 0,32'h0, "R10");
      cyc(0,1,1, 0,0,2'b00, 0,0,32'h0, 0,32'h0, "R10");

      // R9: sweep top nibble in both modes; fault lasts one cycle
      for (int hm = 0; hm < 2; hm++) begin
         if (hm == 1) cyc(1,0,0, 0,0,2'b00, 0,0,32'h0, 0,32'h0, "R2");
         for (int n = 0; n < 16; n++) begin
            cyc(0,0,0, 0,0,2'b00, 0,0,32'h0, 1,{4'(n), 28'h0AB_CDE4} + 32'(n), "R9");
            idle("R9");
         end
      end
      cyc(0,1,1, 0,0,2'b00, 0,0,32'h0, 0,32'h0, "R2");
      // back-to-back protected fetches
      cyc(0,0,0, 0,0,2'b00, 0,0,32'h0, 1,32'hF000_0000, "R9");
      cyc(0,0,0, 0,0,2'b00, 0,0,32'h0, 1,32'hFFFF_FFFC, "R9");
      idle("R9");
      cyc(0,0,0, 0,0,2'b00, 0,0,32'h0, 1,32'hEFFF_FFFC, "R9");

      // R10: fetch judged against the mode before a same-cycle change
      cyc(1,0,0, 0,0,2'b00, 0,0,32'h0, 1,32'hF123_4560, "R10");
      cyc(0,1,1, 0,0,2'b00, 0,0,32'h0, 1,32'hF654_3210, "R10");
      idle("R10");

      // R1: reset again from a busy state
      cyc(1,0,0, 1,1,2'b11, 1,0,32'h5555_5555, 0,32'h0, "R1");
      rst_n = 1'b0;
      @(posedge clk); @(negedge clk);
      rst_n = 1'b1;
      m_hdl = 0; m_ctrl = 0; m_sp[0] = 0; m_sp[1] = 0; m_fault = 0;
      check_all("R1");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule